// File: doc/BRIEF.md
# Indexed Host Register Port with Packet Ring Readout

This block is the slave side of a simple microprocessor bus. It offers the host only two locations, chosen by a command-select input. The index location holds an 8-bit register number. The data location moves a value to or from the register that the index currently names. A host therefore writes the register number first and then transfers the value through the data location.

Behind the index there are three things:
- A control register with a self-timed software reset.
- A few byte-wide scratch registers.
- A 14-bit read pointer into a packet buffer.

The packet buffer itself sits outside the block. It is reached through two byte lanes that the block addresses. The receive region of the buffer runs from 0x0C00 to 0x3FFF and behaves as a ring. Received frames are stored there, each with a 4-byte header (status and length) ahead of the payload.

Two data-port registers read the buffer at the pointer:
- The peek register leaves the pointer where it is.
- The pop register moves the pointer on after the read.

A strap input chooses 8-bit or 16-bit data transfers. It is captured once, just after reset, and sets how many bytes each pop consumes.

Top module: `idx_host_port`

## Requirements
- R1: With `cmd` low, an accepted write loads `wdata` into the index latch. An accepted read returns the index in `rdata[7:0]`, with `rdata[15:8]` zero. The index is 0x00 after reset.
- R2: A write is accepted only when `cs_n` and `wr_n` are both low. A read is accepted only when `cs_n` and `rd_n` are low and `wr_n` is high. With no accepted read, `rdata` is 0, and a strobe without chip-select changes no register.
- R3: `strap_wide` is captured on the first clock after reset release: 1 selects 16-bit mode and 0 selects 8-bit mode. Later changes of the strap have no effect. In 8-bit mode `rdata[15:8]` is always 0.
- R4: Scratch registers at indexes 0x01 to 0x04 read back the last byte written to them. Bits 7:1 of the control register at index 0x00 read back as written. All of these reset to 0.
- R5: A data-port read of any index not listed in R1 to R11 returns 0, and a data-port write to such an index changes nothing readable.
- R6: Index 0xF4 holds pointer bits 7:0 and index 0xF5 holds pointer bits 13:8 (in data bits 5:0). Both can be written and read back. The pointer resets to 0x0C00.
- R7: A data-port read of index 0xF0 returns buffer data at the pointer and leaves the pointer unchanged.
- R8: A data-port read of index 0xF2 returns buffer data at the pointer. The pointer then advances by 1 in 8-bit mode or by 2 in 16-bit mode.
- R9: In 16-bit mode, buffer data is little-endian: `rdata[7:0]` is the byte at the pointer and `rdata[15:8]` is the byte at the next ring address. In 8-bit mode `rdata[7:0]` is the byte at the pointer.
- R10: Advancing past 0x3FFF continues at 0x0C00. This applies both to the pointer and to the second byte of a 16-bit read, so 0x3FFF+1 gives 0x0C00 and 0x3FFF+2 gives 0x0C01.
- R11: Writing 1 to bit 0 of index 0x00 starts a software reset. Bit 0 then reads 1 for `SWRST_CYCLES` cycles and afterwards reads 0. The reset returns the scratch registers, control bits 7:1 and the pointer to their reset values. Register writes and pops are ignored while the reset runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_wide | input | 1 | Width strap, 1 = 16-bit transfers |
| cs_n | input | 1 | Chip select, active low |
| cmd | input | 1 | 0 = index location, 1 = data location |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| wdata | input | 8 | Write data byte |
| rdata | output | 16 | Read data, valid during an accepted read |
| mem_addr_lo | output | 14 | Buffer address of the byte at the pointer |
| mem_addr_hi | output | 14 | Buffer address of the next ring byte |
| mem_rd_lo | input | 8 | Buffer byte at `mem_addr_lo` |
| mem_rd_hi | input | 8 | Buffer byte at `mem_addr_hi` |

## Verification
Read data depends on the current state and the strobes, so it is due in the same cycle as the accepted read. The bench samples it one nanosecond after driving the strobe, before the clock edge. Writes, pops and the start of a software reset take effect at the edge that ends the access. The bench therefore checks their results only through a later access. The software-reset bit is sampled well inside and well past its `SWRST_CYCLES` window rather than on its exact edge.

// File: rtl/idxp_pkg.sv
`timescale 1ns/1ps
package idxp_pkg;
  localparam logic [7:0] IDX_CTRL   = 8'h00;
  localparam logic [7:0] IDX_PEEK   = 8'hF0;
  localparam logic [7:0] IDX_POP    = 8'hF2;
  localparam logic [7:0] IDX_PTR_LO = 8'hF4;
  localparam logic [7:0] IDX_PTR_HI = 8'hF5;

  typedef struct packed {
    logic wr_idx;
    logic wr_dat;
    logic rd_idx;
    logic rd_dat;
  } bus_acc_t;
endpackage

// File: rtl/idxp_rst_sync.sv
`timescale 1ns/1ps
module idxp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/idxp_host_decode.sv
`timescale 1ns/1ps
module idxp_host_decode
  import idxp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       cmd,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic [7:0] wdata,
  output bus_acc_t   acc,
  output logic [7:0] index
);
  logic       wr_any, rd_any;
  logic [7:0] index_d;

  assign wr_any = !cs_n && !wr_n;
  assign rd_any = !cs_n && !rd_n && wr_n;

  always_comb begin
    acc.wr_idx = wr_any && !cmd;
    acc.wr_dat = wr_any &&  cmd;
    acc.rd_idx = rd_any && !cmd;
    acc.rd_dat = rd_any &&  cmd;
  end

  always_comb begin
    index_d = index;
    if (acc.wr_idx) index_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) index <= 8'h00;
    else        index <= index_d;
  end

  AST_IDX_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    acc.wr_idx |=> index == $past(wdata)); // R1
  AST_ACC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({acc.wr_idx, acc.wr_dat, acc.rd_idx, acc.rd_dat})); // R2
endmodule

// File: rtl/idxp_reg_file.sv
`timescale 1ns/1ps
module idxp_reg_file
  import idxp_pkg::*;
#(
  parameter int NUM_SCRATCH  = 4,
  parameter int SWRST_CYCLES = 2500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strap_wide,
  input  logic       wr_en,
  input  logic [7:0] index,
  input  logic [7:0] wdata,
  output logic       wide,
  output logic       busy,
  output logic [7:0] rdata
);
  localparam int CW = $clog2(SWRST_CYCLES + 1);

  logic          mode_done_q, wide_q, wide_d;
  logic          busy_q, busy_d, start;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [6:0]    ctrl_hi_q, ctrl_hi_d;
  logic [7:0]    scr_q [NUM_SCRATCH];
  logic [7:0]    scr_d [NUM_SCRATCH];

  assign start = wr_en && !busy_q && (index == IDX_CTRL) && wdata[0];
  assign wide_d = mode_done_q ? wide_q : strap_wide;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end else if (start) begin
      busy_d = 1'b1;
      cnt_d  = CW'(SWRST_CYCLES - 1);
    end
  end

  always_comb begin
    ctrl_hi_d = ctrl_hi_q;
    if (busy_q || start)                             ctrl_hi_d = '0;
    else if (wr_en && index == IDX_CTRL)             ctrl_hi_d = wdata[7:1];
    for (int i = 0; i < NUM_SCRATCH; i++) begin
      scr_d[i] = scr_q[i];
      if (busy_q || start)                           scr_d[i] = '0;
      else if (wr_en && index == 8'(i + 1))          scr_d[i] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_done_q <= 1'b0;
      wide_q      <= 1'b0;
      busy_q      <= 1'b0;
      cnt_q       <= '0;
      ctrl_hi_q   <= '0;
      for (int i = 0; i < NUM_SCRATCH; i++) scr_q[i] <= '0;
    end else begin
      mode_done_q <= 1'b1;
      wide_q      <= wide_d;
      busy_q      <= busy_d;
      cnt_q       <= cnt_d;
      ctrl_hi_q   <= ctrl_hi_d;
      for (int i = 0; i < NUM_SCRATCH; i++) scr_q[i] <= scr_d[i];
    end
  end

  always_comb begin
    rdata = '0;
    if (index == IDX_CTRL) rdata = {ctrl_hi_q, busy_q};
    for (int i = 0; i < NUM_SCRATCH; i++)
      if (index == 8'(i + 1)) rdata = scr_q[i];
  end

  assign wide = wide_q;
  assign busy = busy_q;

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    mode_done_q |=> $stable(wide_q)); // R3
  AST_SWRST_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0) |=> busy_q); // R11
  AST_SWRST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q == '0) |=> !busy_q); // R11
endmodule

// File: rtl/idxp_rd_ptr.sv
`timescale 1ns/1ps
module idxp_rd_ptr #(
  parameter int AW        = 14,
  parameter int RING_BASE = 'h0C00,
  parameter int RING_END  = 'h3FFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wide,
  input  logic          ld_lo,
  input  logic          ld_hi,
  input  logic [7:0]    ld_data,
  input  logic          peek,
  input  logic          pop,
  output logic [AW-1:0] ptr,
  output logic [AW-1:0] addr_next
);
  localparam logic [AW:0]   END_W  = (AW+1)'(RING_END);
  localparam logic [AW:0]   SPAN_W = (AW+1)'(RING_END - RING_BASE + 1);
  localparam logic [AW-1:0] BASE_A = AW'(RING_BASE);
  localparam logic [AW-1:0] END_A  = AW'(RING_END);

  logic [AW-1:0] ptr_q, ptr_d;
  logic [AW:0]   sum_step, sum_one, adv, nxt1;
  logic [15:0]   hi_full;
  logic          unused_bits;

  assign sum_step = {1'b0, ptr_q} + (wide ? (AW+1)'(2) : (AW+1)'(1));
  assign sum_one  = {1'b0, ptr_q} + (AW+1)'(1);
  assign adv      = (sum_step > END_W) ? sum_step - SPAN_W : sum_step;
  assign nxt1     = (sum_one  > END_W) ? sum_one  - SPAN_W : sum_one;
  assign hi_full  = {ld_data, 8'(ptr_q)};
  assign unused_bits = ^hi_full ^ adv[AW] ^ nxt1[AW];

  always_comb begin
    ptr_d = ptr_q;
    if (clr)        ptr_d = BASE_A;
    else if (ld_lo) ptr_d = {ptr_q[AW-1:8], ld_data};
    else if (ld_hi) ptr_d = hi_full[AW-1:0];
    else if (pop)   ptr_d = adv[AW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= BASE_A;
    else        ptr_q <= ptr_d;
  end

  assign ptr       = ptr_q;
  assign addr_next = nxt1[AW-1:0];

  AST_PEEK_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (peek && !clr) |=> $stable(ptr_q)); // R7
  AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !clr && !wide && ptr_q < END_A) |=> ptr_q == $past(ptr_q) + 1'b1); // R8
  AST_RING_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !clr && ptr_q >= BASE_A && ptr_q <= END_A)
      |=> (ptr_q >= BASE_A && ptr_q <= END_A)); // R10
  AST_CLR_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ptr_q == BASE_A); // R11
endmodule

// File: rtl/idx_host_port.sv
`timescale 1ns/1ps
module idx_host_port
  import idxp_pkg::*;
#(
  parameter int AW           = 14,
  parameter int RING_BASE    = 'h0C00,
  parameter int RING_END     = 'h3FFF,
  parameter int NUM_SCRATCH  = 4,
  parameter int SWRST_CYCLES = 2500
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strap_wide,
  input  logic          cs_n,
  input  logic          cmd,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [7:0]    wdata,
  output logic [15:0]   rdata,
  output logic [AW-1:0] mem_addr_lo,
  output logic [AW-1:0] mem_addr_hi,
  input  logic [7:0]    mem_rd_lo,
  input  logic [7:0]    mem_rd_hi
);
  logic          rst_i_n;
  bus_acc_t      acc;
  logic [7:0]    index, rf_rdata;
  logic          wide, busy, reg_wr;
  logic          ld_lo, ld_hi, peek, pop;
  logic [AW-1:0] ptr;
  logic [15:0]   ptr_ext, data_word;

  idxp_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  idxp_host_decode u_dec (
    .clk(clk), .rst_n(rst_i_n), .cs_n(cs_n), .cmd(cmd), .rd_n(rd_n),
    .wr_n(wr_n), .wdata(wdata), .acc(acc), .index(index)
  );

  assign reg_wr = acc.wr_dat;

  idxp_reg_file #(.NUM_SCRATCH(NUM_SCRATCH), .SWRST_CYCLES(SWRST_CYCLES)) u_rf (
    .clk(clk), .rst_n(rst_i_n), .strap_wide(strap_wide), .wr_en(reg_wr),
    .index(index), .wdata(wdata), .wide(wide), .busy(busy), .rdata(rf_rdata)
  );

  assign ld_lo = acc.wr_dat && !busy && index == IDX_PTR_LO;
  assign ld_hi = acc.wr_dat && !busy && index == IDX_PTR_HI;
  assign peek  = acc.rd_dat && index == IDX_PEEK;
  assign pop   = acc.rd_dat && !busy && index == IDX_POP;

  idxp_rd_ptr #(.AW(AW), .RING_BASE(RING_BASE), .RING_END(RING_END)) u_ptr (
    .clk(clk), .rst_n(rst_i_n), .clr(busy), .wide(wide), .ld_lo(ld_lo),
    .ld_hi(ld_hi), .ld_data(wdata), .peek(peek), .pop(pop), .ptr(ptr),
    .addr_next(mem_addr_hi)
  );

  assign mem_addr_lo = ptr;
  assign ptr_ext     = 16'(ptr);
  assign data_word   = wide ? {mem_rd_hi, mem_rd_lo} : {8'h00, mem_rd_lo};

  always_comb begin
    rdata = 16'h0000;
    if (acc.rd_idx) begin
      rdata = {8'h00, index};
    end else if (acc.rd_dat) begin
      case (index)
        IDX_PEEK, IDX_POP: rdata = data_word;
        IDX_PTR_LO:        rdata = {8'h00, ptr_ext[7:0]};
        IDX_PTR_HI:        rdata = {8'h00, ptr_ext[15:8]};
        default:           rdata = {8'h00, rf_rdata};
      endcase
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cs_n || rd_n) |-> rdata == 16'h0000); // R2
  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_i_n)
    !wide |-> rdata[15:8] == 8'h00); // R3
endmodule

// File: tb/idx_host_port_tb.sv
`timescale 1ns/1ps
module idx_host_port_tb;
  localparam int SWR = 40;

  logic        clk, rst_n, strap_wide, cs_n, cmd, rd_n, wr_n;
  logic [7:0]  wdata, mem_rd_lo, mem_rd_hi;
  logic [15:0] rdata;
  logic [13:0] mem_addr_lo, mem_addr_hi;

  int   n_chk, n_fail;
  bit   finished;
  logic [13:0] ptr_m;
  bit   wide_m;

  idx_host_port #(.SWRST_CYCLES(SWR)) u_dut (
    .clk(clk), .rst_n(rst_n), .strap_wide(strap_wide), .cs_n(cs_n), .cmd(cmd),
    .rd_n(rd_n), .wr_n(wr_n), .wdata(wdata), .rdata(rdata),
    .mem_addr_lo(mem_addr_lo), .mem_addr_hi(mem_addr_hi),
    .mem_rd_lo(mem_rd_lo), .mem_rd_hi(mem_rd_hi)
  );

  function automatic logic [7:0] mb(input logic [13:0] a);
    return 8'(a * 13) ^ {2'b00, a[13:8]};
  endfunction

  function automatic logic [13:0] nxt(input logic [13:0] p, input int s);
    int t = int'(p) + s;
    if (t > 'h3FFF) t = t - 'h3400;
    return 14'(t);
  endfunction

  function automatic logic [15:0] exp_word(input logic [13:0] p);
    return wide_m ? {mb(nxt(p, 1)), mb(p)} : {8'h00, mb(p)};
  endfunction

  assign mem_rd_lo = mb(mem_addr_lo);
  assign mem_rd_hi = mb(mem_addr_hi);

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", tag, got, exp);
    end
  endtask

  task automatic access(input logic c, input logic w, input logic [7:0] d,
                        output logic [15:0] r);
    @(negedge clk);
    cs_n = 1'b0; cmd = c; wr_n = !w; rd_n = w; wdata = d;
    #1 r = rdata;
    @(posedge clk);
    #1 cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic wreg(input logic [7:0] idx, input logic [7:0] v);
    logic [15:0] r;
    access(1'b0, 1'b1, idx, r);
    access(1'b1, 1'b1, v, r);
  endtask

  task automatic rreg(input logic [7:0] idx, output logic [15:0] r);
    logic [15:0] t;
    access(1'b0, 1'b1, idx, t);
    access(1'b1, 1'b0, 8'h00, r);
  endtask

  task automatic load_ptr(input logic [13:0] p);
    wreg(8'hF4, p[7:0]);
    wreg(8'hF5, {2'b00, p[13:8]});
    ptr_m = p;
  endtask

  task automatic chk_ptr(input string tag);
    logic [15:0] r;
    rreg(8'hF4, r); chk(tag, r, {8'h00, ptr_m[7:0]});
    rreg(8'hF5, r); chk(tag, r, {10'h000, ptr_m[13:8]});
  endtask

  task automatic do_peek(input string tag);
    logic [15:0] r;
    rreg(8'hF0, r); chk(tag, r, exp_word(ptr_m));
  endtask

  task automatic do_pop(input string tag);
    logic [15:0] r;
    rreg(8'hF2, r); chk(tag, r, exp_word(ptr_m));
    ptr_m = nxt(ptr_m, wide_m ? 2 : 1);
  endtask

  task automatic run_mode(input bit w);
    logic [15:0] r;
    logic [7:0]  v;
    rst_n = 1'b0; strap_wide = w;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (6) @(posedge clk);
    wide_m = w; ptr_m = 14'h0C00;

    access(1'b0, 1'b0, 8'h00, r); chk("R1 index reset", r, 16'h0000);
    chk_ptr("R6 pointer reset");
    rreg(8'h01, r); chk("R4 scratch reset", r, 16'h0000);

    strap_wide = !w;                       // R3: later strap change ignored

    access(1'b0, 1'b1, 8'h5C, r);
    access(1'b0, 1'b0, 8'h00, r); chk("R1 index readback", r, 16'h005C);

    for (int i = 1; i <= 4; i++) begin
      v = 8'($urandom);
      wreg(8'(i), v); rreg(8'(i), r); chk("R4 scratch", r, {8'h00, v});
    end
    wreg(8'h00, 8'hA4); rreg(8'h00, r); chk("R4 control upper bits", r, 16'h00A4);
    wreg(8'h00, 8'h00);

    wreg(8'hF3, 8'h99); rreg(8'hF3, r); chk("R5 unimplemented F3", r, 16'h0000);
    wreg(8'h05, 8'h77); rreg(8'h05, r); chk("R5 unimplemented 05", r, 16'h0000);

    wreg(8'h02, 8'h33);
    @(negedge clk); cs_n = 1'b1; cmd = 1'b1; wr_n = 1'b0; wdata = 8'h77;
    @(negedge clk); wr_n = 1'b1; rd_n = 1'b0;
    #1 chk("R2 read without select", rdata, 16'h0000);
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b1;
    #1 chk("R2 select without strobe", rdata, 16'h0000);
    @(negedge clk); cs_n = 1'b1;
    rreg(8'h02, r); chk("R2 write without select ignored", r, 16'h0033);

    do_peek("R7 peek at base");
    do_peek("R7 peek repeat");
    chk_ptr("R7 pointer unchanged");
    rreg(8'hF0, r);
    if (!w) chk("R3 upper byte zero in 8-bit", r & 16'hFF00, 16'h0000);
    else    chk("R9 little-endian word", r, {mb(14'h0C01), mb(14'h0C00)});
    do_pop("R8 pop data");
    chk_ptr(w ? "R3 R8 step two" : "R3 R8 step one");

    load_ptr(14'h3FFF);
    do_peek("R10 R9 read across wrap");
    do_pop("R10 pop at end");
    chk_ptr("R10 pointer wrapped");
    load_ptr(14'h3FFE);
    do_pop("R10 pop near end"); do_pop("R10 pop near end"); do_pop("R10 pop after wrap");
    chk_ptr("R10 pointer after wrap");

    for (int k = 0; k < 200; k++) begin
      case ($urandom % 5)
        0: load_ptr(($urandom % 2) ? 14'(14'h3FF0 + $urandom % 16)
                                   : 14'(14'h0C00 + $urandom % 'h3400));
        1: do_peek("R7 random peek");
        2: chk_ptr("R6 random pointer readback");
        default: do_pop("R8 random pop");
      endcase
    end

    load_ptr(14'h1234);
    wreg(8'h01, 8'hAB);
    wreg(8'h00, 8'h01);
    rreg(8'h00, r); chk("R11 reset bit set", r, 16'h0001);
    wreg(8'h03, 8'h5A);
    repeat (SWR - 12) @(posedge clk);
    rreg(8'h00, r); chk("R11 reset bit still set", r, 16'h0001);
    repeat (12) @(posedge clk);
    rreg(8'h00, r); chk("R11 reset bit cleared", r, 16'h0000);
    rreg(8'h01, r); chk("R11 scratch cleared", r, 16'h0000);
    rreg(8'h03, r); chk("R11 write during reset ignored", r, 16'h0000);
    ptr_m = 14'h0C00;
    chk_ptr("R11 pointer restored");
  endtask

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h00C0FFEE);
    clk = 1'b0; rst_n = 1'b0; strap_wide = 1'b0;
    cs_n = 1'b1; cmd = 1'b0; rd_n = 1'b1; wr_n = 1'b1; wdata = 8'h00;
    n_chk = 0; n_fail = 0; finished = 0;
    run_mode(1'b0);
    run_mode(1'b1);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule